// File: doc/BRIEF.md
# Instruction Prefetch Buffer with First-Word Bypass

This block sits between the miss path of an instruction cache and the fetch stage of a pipeline. When the cache reports a miss, the block takes the missing address and aligns it to a block boundary. It then asks external memory for the whole block and collects the returning words in a small buffer that has one valid bit per slot. The pipeline does not wait for the full block. If a fetch names the word that memory is returning in that cycle, the word goes straight to the instruction output. If the word was latched earlier, the buffer serves it. If the word has not arrived yet, the fetch stalls.

Once every slot of the block has arrived, a one-cycle pulse offers the block and its address to the cache for refill. A fetch that leaves the block while the fill is still in progress, such as a taken branch, abandons the fill. Memory still returns the rest of the words, but they are discarded, the buffer is emptied and no refill pulse is produced. New misses are accepted again once the last word of the burst has gone by. The defaults are four slots of 32-bit instructions, so a block is 16 bytes.

Top module: `ifetch_prefetch_buf`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, instr_valid, fetch_stall and fill_done are all 0.
- R2: A miss is accepted in a cycle where miss_valid and miss_ready are both 1. From the next cycle, mem_req_valid is 1 and mem_req_addr holds the miss address with bits [3:0] cleared. Both stay unchanged until mem_req_ready is seen. miss_ready stays 0 until the burst of the accepted fill has ended.
- R3: Memory returns one word per mem_rvalid cycle, in ascending slot order starting at slot 0. Address bits [3:2] choose the slot, and fetch addresses are word aligned (bits [1:0] are 0).
- R4: A fetch to the slot whose word arrives in the same cycle gets instr_valid=1 and instr_data equal to mem_rdata in that cycle, with fetch_stall=0.
- R5: During a live fill, a fetch inside the block to a slot that has not arrived gives fetch_stall=1 and instr_valid=0. With fetch_valid=0, fetch_stall is 0.
- R6: A fetch inside the block to a slot already latched gives instr_valid=1 with that slot's word. This holds both during the fill and after it, until the next miss is accepted.
- R7: fill_done is 1 for exactly one cycle, the cycle after the last slot is latched. In that cycle fill_addr is the block address and fill_block holds slot k in bits [32k+31:32k].
- R8: A fetch outside the block while a request or fill is in progress cancels the fill. The remaining words are dropped, fill_done stays 0, and fetches to that block then give instr_valid=0 and fetch_stall=0. miss_ready returns to 1 after the last word of the burst.
- R9: When no fill is in progress, a fetch outside the buffered block gives instr_valid=0 and fetch_stall=0 and leaves the buffered words intact.
- R10: mem_rvalid outside a fill has no effect on the buffered words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss request |
| miss_addr | input | 32 | Address that missed |
| miss_ready | output | 1 | Block idle, miss can be taken |
| mem_req_valid | output | 1 | Block read request to memory |
| mem_req_addr | output | 32 | Aligned block address of the request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Returned word valid |
| mem_rdata | input | 32 | Returned word |
| fetch_valid | input | 1 | Pipeline fetch request |
| fetch_addr | input | 32 | Pipeline fetch address |
| instr_valid | output | 1 | Instruction delivered this cycle |
| instr_data | output | 32 | Delivered instruction |
| fetch_stall | output | 1 | Fetch must wait for its word |
| fill_done | output | 1 | One-cycle refill pulse |
| fill_addr | output | 32 | Block address for refill |
| fill_block | output | 128 | Complete block, slot 0 in the low bits |

## Verification
Fills are run with zero, mixed and random wait states before each word. Three pipeline behaviours are used against them. In the first, the pipeline fetches each word just as it arrives, so every delivery must come from the bypass path and every wait cycle must stall. In the second, the pipeline trails by one slot, so hits must come from the latched copy while later words are still arriving. In the third, the pipeline fetches nothing until the fill has ended, which shows the buffer keeps the whole block. Cancellation is tried both during the request and during the fill, to confirm that late words are dropped and no refill pulse appears.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_FILL = 2'd2
   } fill_state_e;

endpackage

// File: rtl/pfb_slot_store.sv
module pfb_slot_store #(
   parameter int DATA_W = 32,
   parameter int SLOTS  = 4,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    wr_en,
   input  logic [SLOT_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [SLOTS-1:0]        slot_vld,
   output logic [SLOTS*DATA_W-1:0] block
);

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic             hit;
      logic [DATA_W-1:0] word_q;
      logic             vld_q;

      assign hit = wr_en && (wr_idx == SLOT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            word_q <= '0;
         end else begin
            if (clr)      vld_q <= 1'b0;
            else if (hit) vld_q <= 1'b1;
            if (hit) word_q <= wr_data;
         end
      end

      assign slot_vld[g] = vld_q;
      assign block[g*DATA_W +: DATA_W] = word_q;
   end

   // R3: words land in ascending order, so every lower slot is already valid
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(slot_vld) == int'(wr_idx)));

endmodule

// File: rtl/pfb_fill_ctrl.sv
module pfb_fill_ctrl
   import pfb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 4,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int OFS_W  = SLOT_W + 2,
   localparam int TAG_W  = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [TAG_W-1:0]  miss_tag,
   output logic              miss_ready,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   input  logic              mem_rvalid,
   input  logic              fetch_valid,
   input  logic [TAG_W-1:0]  fetch_tag,
   output logic [TAG_W-1:0]  blk_tag,
   output logic              live,
   output logic              busy,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_idx,
   output logic              clr,
   output logic              fill_done
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   fill_state_e       state_q;
   logic [TAG_W-1:0]  tag_q;
   logic              live_q;
   logic [SLOT_W-1:0] cnt_q;
   logic              done_q;
   logic              accept;
   logic              cancel;

   assign accept = (state_q == FS_IDLE) && miss_valid;
   assign cancel = fetch_valid && live_q && (state_q != FS_IDLE) && (fetch_tag != tag_q);
   assign wr_en  = (state_q == FS_FILL) && mem_rvalid && live_q && !cancel;
   assign clr    = accept || cancel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         tag_q   <= '0;
         live_q  <= 1'b0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= wr_en && (cnt_q == LAST);
         if (cancel) live_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: if (accept) begin
               tag_q   <= miss_tag;
               live_q  <= 1'b1;
               state_q <= FS_REQ;
            end
            FS_REQ: if (mem_req_ready) begin
               cnt_q   <= '0;
               state_q <= FS_FILL;
            end
            FS_FILL: if (mem_rvalid) begin
               if (cnt_q == LAST) state_q <= FS_IDLE;
               else               cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign miss_ready    = (state_q == FS_IDLE);
   assign mem_req_valid = (state_q == FS_REQ);
   assign blk_tag       = tag_q;
   assign live          = live_q;
   assign busy          = (state_q != FS_IDLE);
   assign wr_idx        = cnt_q;
   assign fill_done     = done_q;

   // R2: request and its address hold until memory takes it
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(blk_tag)));

   // R3: the last word of a burst ends the fill
   a_r3_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == FS_FILL) && mem_rvalid && (cnt_q == LAST)) |=> miss_ready);

   // R8: a cancelled fill never raises the refill pulse
   a_r8_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(live_q) |-> !done_q);

endmodule

// File: rtl/pfb_fetch_port.sv
module pfb_fetch_port #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SLOTS     = 4,
   parameter bit BYPASS_EN = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int OFS_W  = SLOT_W + 2,
   localparam int TAG_W  = ADDR_W - OFS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fetch_valid,
   input  logic [ADDR_W-1:0]       fetch_addr,
   input  logic [TAG_W-1:0]        blk_tag,
   input  logic [SLOTS-1:0]        slot_vld,
   input  logic [SLOTS*DATA_W-1:0] block,
   input  logic                    live,
   input  logic                    busy,
   input  logic                    wr_en,
   input  logic [SLOT_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    instr_valid,
   output logic [DATA_W-1:0]       instr_data,
   output logic                    fetch_stall
);

   logic [SLOT_W-1:0] sel;
   logic              in_blk;
   logic              buf_hit;
   logic              byp;
   logic              pending;
   logic [DATA_W-1:0] buf_word;

   assign sel      = fetch_addr[OFS_W-1:2];
   assign in_blk   = fetch_valid && (fetch_addr[ADDR_W-1:OFS_W] == blk_tag);
   assign buf_hit  = in_blk && slot_vld[sel];
   assign buf_word = block[sel*DATA_W +: DATA_W];

   if (BYPASS_EN) begin : g_bypass
      assign byp = in_blk && wr_en && (wr_idx == sel);
   end else begin : g_no_bypass
      logic unused_byp;
      assign unused_byp = ^{wr_idx, wr_data};
      assign byp = 1'b0;
   end

   assign pending     = in_blk && live && busy && !slot_vld[sel];
   assign instr_valid = buf_hit || byp;
   assign instr_data  = buf_hit ? buf_word : wr_data;
   assign fetch_stall = pending && !byp;

   // R3: fetch addresses are word aligned
   a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (fetch_addr[1:0] == 2'b00));

   // R4: an unlatched slot can only be delivered from the returning word
   a_r4_bypass_data: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !slot_vld[sel]) |-> (wr_en && instr_data == wr_data));

   // R5: a stalled fetch is never also delivered
   a_r5_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> (!instr_valid && busy));

endmodule

// File: rtl/ifetch_prefetch_buf.sv
module ifetch_prefetch_buf #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SLOTS     = 4,
   parameter bit BYPASS_EN = 1'b1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int OFS_W  = SLOT_W + 2,
   localparam int TAG_W  = ADDR_W - OFS_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    miss_valid,
   input  logic [ADDR_W-1:0]       miss_addr,
   output logic                    miss_ready,
   output logic                    mem_req_valid,
   output logic [ADDR_W-1:0]       mem_req_addr,
   input  logic                    mem_req_ready,
   input  logic                    mem_rvalid,
   input  logic [DATA_W-1:0]       mem_rdata,
   input  logic                    fetch_valid,
   input  logic [ADDR_W-1:0]       fetch_addr,
   output logic                    instr_valid,
   output logic [DATA_W-1:0]       instr_data,
   output logic                    fetch_stall,
   output logic                    fill_done,
   output logic [ADDR_W-1:0]       fill_addr,
   output logic [SLOTS*DATA_W-1:0] fill_block
);

   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_chk_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W <= OFS_W) begin : g_chk_addr
      $error("ADDR_W must exceed the block offset width");
   end

   logic [TAG_W-1:0]  blk_tag;
   logic              live;
   logic              busy;
   logic              wr_en;
   logic [SLOT_W-1:0] wr_idx;
   logic              clr;
   logic [SLOTS-1:0]  slot_vld;
   logic              unused_low;

   assign unused_low = ^miss_addr[OFS_W-1:0];

   pfb_fill_ctrl #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_valid    (miss_valid),
      .miss_tag      (miss_addr[ADDR_W-1:OFS_W]),
      .miss_ready    (miss_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rvalid    (mem_rvalid),
      .fetch_valid   (fetch_valid),
      .fetch_tag     (fetch_addr[ADDR_W-1:OFS_W]),
      .blk_tag       (blk_tag),
      .live          (live),
      .busy          (busy),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .clr           (clr),
      .fill_done     (fill_done)
   );

   pfb_slot_store #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (mem_rdata),
      .slot_vld (slot_vld),
      .block    (fill_block)
   );

   pfb_fetch_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .BYPASS_EN(BYPASS_EN)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .blk_tag     (blk_tag),
      .slot_vld    (slot_vld),
      .block       (fill_block),
      .live        (live),
      .busy        (busy),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (mem_rdata),
      .instr_valid (instr_valid),
      .instr_data  (instr_data),
      .fetch_stall (fetch_stall)
   );

   assign mem_req_addr = {blk_tag, {OFS_W{1'b0}}};
   assign fill_addr    = {blk_tag, {OFS_W{1'b0}}};

   // R7: the refill pulse only appears with every slot valid
   a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> ($countones(slot_vld) == SLOTS && live));

   // R7: the pulse lasts one cycle
   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);

   // R1: no memory request while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready |-> !mem_req_valid);

endmodule

// File: tb/ifetch_prefetch_buf_test.sv
module ifetch_prefetch_buf_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         miss_valid = 1'b0;
   logic [31:0]  miss_addr = '0;
   logic         miss_ready;
   logic         mem_req_valid;
   logic [31:0]  mem_req_addr;
   logic         mem_req_ready = 1'b0;
   logic         mem_rvalid = 1'b0;
   logic [31:0]  mem_rdata = '0;
   logic         fetch_valid = 1'b0;
   logic [31:0]  fetch_addr = '0;
   logic         instr_valid;
   logic [31:0]  instr_data;
   logic         fetch_stall;
   logic         fill_done;
   logic [31:0]  fill_addr;
   logic [127:0] fill_block;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ifetch_prefetch_buf uut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .instr_valid(instr_valid), .instr_data(instr_data), .fetch_stall(fetch_stall),
      .fill_done(fill_done), .fill_addr(fill_addr), .fill_block(fill_block)
   );

   // entry: block address (with offset), four wait nibbles (slot 0 lowest), fetch mode
   // mode 0: fetch each word as it arrives; 1: fetch after fill; 2: trail by one slot
   localparam logic [49:0] VEC [6] = '{
      {32'h0000_1000, 16'h0000, 2'd0},
      {32'h0000_2044, 16'h1230, 2'd0},
      {32'h8000_00F8, 16'h0302, 2'd2},
      {32'h1234_5670, 16'h2121, 2'd1},
      {32'hFFFF_FFF0, 16'h0010, 2'd2},
      {32'h0000_0004, 16'h3003, 2'd0}
   };

   function automatic logic [31:0] word_of(input logic [31:0] blk, input int s);
      return (blk * 32'h0001_9E37) ^ (32'h5A00_0000 >> s) ^ 32'(s);
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive_fetch(input logic [1:0] mode, input int k, input logic [31:0] blk);
      if (mode == 2'd1) begin
         fetch_valid = 1'b0;
      end else begin
         fetch_valid = 1'b1;
         fetch_addr  = blk + 32'((mode == 2'd0 || k == 0) ? k * 4 : (k - 1) * 4);
      end
   endtask

   task automatic expect_fetch(input logic [1:0] mode, input int k,
                               input logic [31:0] blk, input bit arriving);
      int s;
      if (mode == 2'd1) begin
         chk("R5 idle fetch valid", instr_valid, 0);
         chk("R5 idle fetch stall", fetch_stall, 0);
      end else begin
         s = (mode == 2'd0 || k == 0) ? k : k - 1;
         if (s < k) begin
            chk("R6 latched hit", instr_valid, 1);
            chk("R6 latched data", instr_data, word_of(blk, s));
         end else if (arriving) begin
            chk("R4 bypass valid", {instr_valid, fetch_stall}, 2'b10);
            chk("R4 bypass data", instr_data, word_of(blk, k));
         end else begin
            chk("R5 stall", {instr_valid, fetch_stall}, 2'b01);
         end
      end
   endtask

   task automatic run_fill(input logic [31:0] a, input logic [15:0] w, input logic [1:0] mode);
      logic [31:0] blk;
      blk = {a[31:4], 4'h0};
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = a; fetch_valid = 1'b0;
      #1 chk("R2 ready before miss", miss_ready, 1);
      @(negedge clk);
      miss_valid = 1'b0; mem_req_ready = 1'b0;
      drive_fetch(mode, 0, blk);
      #1 chk("R2 request", {mem_req_valid, miss_ready}, 2'b10);
      chk("R2 aligned addr", mem_req_addr, blk);
      if (mode != 2'd1) chk("R5 stall during request", fetch_stall, 1);
      @(negedge clk);
      mem_req_ready = 1'b1;
      #1 chk("R2 request held", mem_req_valid, 1);
      chk("R2 address held", mem_req_addr, blk);
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < int'(w[4*k +: 4]); i++) begin
            @(negedge clk);
            mem_req_ready = 1'b0; mem_rvalid = 1'b0;
            drive_fetch(mode, k, blk);
            #1 expect_fetch(mode, k, blk, 1'b0);
         end
         @(negedge clk);
         mem_req_ready = 1'b0; mem_rvalid = 1'b1; mem_rdata = word_of(blk, k);
         drive_fetch(mode, k, blk);
         #1 expect_fetch(mode, k, blk, 1'b1);
      end
      @(negedge clk);
      mem_rvalid = 1'b0; fetch_valid = 1'b0;
      #1 chk("R7 done pulse", fill_done, 1);
      chk("R7 fill addr", fill_addr, blk);
      chk("R7 fill block", fill_block, {word_of(blk, 3), word_of(blk, 2),
                                         word_of(blk, 1), word_of(blk, 0)});
      chk("R2 ready after fill", miss_ready, 1);
      @(negedge clk);
      #1 chk("R7 pulse ends", fill_done, 0);
      if (mode == 2'd1) begin
         for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            fetch_valid = 1'b1; fetch_addr = blk + 32'(s * 4);
            #1 chk("R6 after fill", {instr_valid, fetch_stall}, 2'b10);
            chk("R6 after fill data", instr_data, word_of(blk, s));
         end
      end
      @(negedge clk);
      fetch_valid = 1'b0;
   endtask

   task automatic run_cancel(input logic [31:0] blk, input bit in_req);
      int left;
      bit saw_done;
      saw_done = 1'b0;
      @(negedge clk);
      miss_valid = 1'b1; miss_addr = blk; fetch_valid = 1'b0;
      @(negedge clk);
      miss_valid = 1'b0;
      if (in_req) begin
         mem_req_ready = 1'b0;
         fetch_valid = 1'b1; fetch_addr = blk ^ 32'h0001_0000;
         #1 chk("R8 redirect in request", {instr_valid, fetch_stall}, 2'b00);
         @(negedge clk);
         fetch_valid = 1'b0; mem_req_ready = 1'b1;
         left = 4;
      end else begin
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0; mem_rvalid = 1'b1; mem_rdata = word_of(blk, 0);
         fetch_valid = 1'b1; fetch_addr = blk;
         #1 chk("R4 bypass before cancel", instr_data, word_of(blk, 0));
         @(negedge clk);
         mem_rvalid = 1'b0; fetch_addr = blk + 32'h40;
         #1 chk("R8 redirect in fill", {instr_valid, fetch_stall}, 2'b00);
         left = 3;
      end
      for (int j = 0; j < left; j++) begin
         @(negedge clk);
         mem_req_ready = 1'b0; mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_0000 + 32'(j);
         fetch_valid = 1'b1; fetch_addr = blk + 32'(((j + 1) % 4) * 4);
         #1 chk("R8 dropped word not delivered", {instr_valid, fetch_stall}, 2'b00);
         chk("R8 still busy", miss_ready, 0);
         if (fill_done) saw_done = 1'b1;
      end
      @(negedge clk);
      mem_rvalid = 1'b0; fetch_addr = blk;
      #1 chk("R8 old slot gone", {instr_valid, fetch_stall}, 2'b00);
      if (fill_done) saw_done = 1'b1;
      @(negedge clk);
      fetch_valid = 1'b0;
      #1 if (fill_done) saw_done = 1'b1;
      chk("R8 no refill pulse", saw_done, 0);
      chk("R8 ready again", miss_ready, 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] blk;
      repeat (3) @(negedge clk);
      #1 chk("R1 reset outputs",
             {miss_ready, mem_req_valid, instr_valid, fetch_stall, fill_done}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h0000_0000;
      #1 chk("R1 empty buffer", {instr_valid, fetch_stall}, 2'b00);
      fetch_valid = 1'b0;

      for (int v = 0; v < 6; v++) begin
         run_fill(VEC[v][49:18], VEC[v][17:2], VEC[v][1:0]);
      end

      // random wait states
      for (int r = 0; r < 4; r++) begin
         run_fill(32'h0004_0000 + 32'(r * 16),
                  16'($urandom) & 16'h3333, 2'(r % 3));
      end

      // R9: redirect outside the buffered block with no fill running
      blk = 32'h0004_0030;
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h0009_0000;
      #1 chk("R9 outside idle", {instr_valid, fetch_stall, miss_ready}, 3'b001);
      @(negedge clk);
      fetch_addr = blk + 32'h8;
      #1 chk("R9 buffer intact", instr_data, word_of(blk, 2));
      chk("R9 buffer hit", instr_valid, 1);

      // R10: stray returned word while idle
      @(negedge clk);
      fetch_valid = 1'b0; mem_rvalid = 1'b1; mem_rdata = 32'hBAD0_BAD0;
      @(negedge clk);
      mem_rvalid = 1'b0;
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         fetch_valid = 1'b1; fetch_addr = blk + 32'(s * 4);
         #1 chk("R10 stray word ignored", instr_data, word_of(blk, s));
      end
      @(negedge clk);
      fetch_valid = 1'b0;

      run_cancel(32'h0000_7000, 1'b0);
      run_cancel(32'h0000_8000, 1'b1);
      run_fill(32'h0000_9008, 16'h0101, 2'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule